// File: doc/BRIEF.md
# SPI Serial Clock Divider

This block derives the serial clock of an SPI master from the system clock. The division is done by two counters in cascade. A prescaler takes an even value and produces a tick every pre/2 system cycles. A postscaler counts post+1 of those ticks and then toggles the serial clock. The resulting full serial clock period is (1 + post) × pre system cycles. The smallest ratio is 2, reached with pre = 2 and post = 0. The largest is 256 × 254.

The shift engine has no need to watch the serial clock itself. The block raises a one-cycle pulse in the same cycle that the serial clock leaves its idle level, and a second kind of pulse in the cycle it returns to idle. The idle level follows the clock polarity input.

The prescale, postscale and polarity inputs are captured only while the block is disabled. A running divider therefore never sees its ratio change part-way through a period.

Top module: `spi_clk_div`

## Requirements
- R1: While reset is asserted, sclk_o, lead_o and trail_o are all 0.
- R2: An odd prescale input acts as the even value just below it. For example, 7 behaves as 6.
- R3: A prescale input of 0 or 1 acts as 2.
- R4: While enabled, sclk_o toggles once every (post+1)×(pre/2) system cycles, so one full period takes (1+post)×pre cycles.
- R5: With pre = 2 and post = 0, sclk_o toggles on every system clock edge, which divides the clock by 2.
- R6: When en_i is sampled low at a clock edge, sclk_o takes the value of cpol_i after that edge, and lead_o and trail_o stay 0.
- R7: lead_o is high for exactly the one cycle in which sclk_o has just moved away from the idle level.
- R8: trail_o is high for exactly the one cycle in which sclk_o has just returned to the idle level.
- R9: While the block is enabled, changes on pre_i, post_i and cpol_i have no effect on the sclk_o timing or on its level.
- R10: The counters restart from zero on enable. The first edge of sclk_o comes at the N-th clock edge at which en_i is sampled high, where N = (post+1)×(pre/2).
- R11: With cpol_i = 1, the idle level is 1 and the leading edge is a falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run the divider. When low, the counters clear and the configuration is captured |
| cpol_i | input | 1 | Idle level of the serial clock |
| pre_i | input | 8 | Prescale value, even, from 2 to 254 |
| post_i | input | 8 | Postscale count. The postscaler divides by post_i+1 |
| sclk_o | output | 1 | Serial clock |
| lead_o | output | 1 | Pulse marking a leading edge of sclk_o |
| trail_o | output | 1 | Pulse marking a trailing edge of sclk_o |

## Verification
The divider is tried with several prescale and postscale pairs. The smallest ratio shows that the first toggle happens with no extra cycle of latency. Pairs that load only the prescaler or only the postscaler show that the two counters multiply and do not add. A large pair checks the full width of both counters. Odd prescale values and values below 2 are compared against the even value they should act as, and each run is repeated with the opposite polarity so that the lead and trail pulses can be told apart from the rise and fall of the clock. In one run the fields are changed in mid-flight and the cadence must stay the same. A disable phase with the polarity input toggling shows that the idle level tracks the input one cycle later.

// File: rtl/spi_clk_div_pkg.sv
package spi_clk_div_pkg;
  localparam int unsigned DEF_PRE_W  = 8;
  localparam int unsigned DEF_POST_W = 8;

  typedef enum logic [1:0] {
    EDGE_NONE  = 2'd0,
    EDGE_LEAD  = 2'd1,
    EDGE_TRAIL = 2'd2
  } edge_kind_e;
endpackage

// File: rtl/div_cfg_latch.sv
module div_cfg_latch #(
  parameter int unsigned PRE_W  = 8,
  parameter int unsigned POST_W = 8,
  localparam int unsigned HALF_W = PRE_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              cpol_i,
  input  logic [PRE_W-1:0]  pre_i,
  input  logic [POST_W-1:0] post_i,
  output logic [HALF_W-1:0] half_o,
  output logic [POST_W-1:0] post_o,
  output logic              cpol_o
);
  logic [HALF_W-1:0] half_d;

  // floor(pre/2) rounds odd values down; values below 2 act as 2
  always_comb begin
    half_d = pre_i[PRE_W-1:1];
    if (pre_i < PRE_W'(2)) half_d = HALF_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_o <= HALF_W'(1);
      post_o <= '0;
      cpol_o <= 1'b0;
    end else if (!en_i) begin
      half_o <= half_d;
      post_o <= post_i;
      cpol_o <= cpol_i;
    end
  end

  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(en_i) |-> ($stable(half_o) && $stable(post_o) && $stable(cpol_o))); // R9
  AST_HALF_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half_o != '0); // R3
endmodule

// File: rtl/div_prescaler.sv
module div_prescaler #(
  parameter int unsigned HALF_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [HALF_W-1:0] half_i,
  output logic              tick_o
);
  logic [HALF_W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == half_i - HALF_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!en_i)   cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + HALF_W'(1);
  end

  AST_PRE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < half_i); // R4
  AST_PRE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> cnt_q == '0); // R10
endmodule

// File: rtl/div_postscaler.sv
module div_postscaler #(
  parameter int unsigned POST_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic [POST_W-1:0] post_i,
  output logic              toggle_o
);
  logic [POST_W-1:0] cnt_q;
  logic              wrap;

  assign wrap     = (cnt_q == post_i);
  assign toggle_o = en_i && tick_i && wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!en_i)             cnt_q <= '0;
    else if (tick_i && wrap)    cnt_q <= '0;
    else if (tick_i)            cnt_q <= cnt_q + POST_W'(1);
  end

  AST_POST_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= post_i); // R4
endmodule

// File: rtl/div_sclk_gen.sv
module div_sclk_gen
  import spi_clk_div_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic toggle_i,
  input  logic cpol_idle_i,
  input  logic cpol_cfg_i,
  output logic sclk_o,
  output logic lead_o,
  output logic trail_o
);
  edge_kind_e kind_d, kind_q;

  always_comb begin
    kind_d = EDGE_NONE;
    if (en_i && toggle_i) kind_d = (sclk_o == cpol_cfg_i) ? EDGE_LEAD : EDGE_TRAIL;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_o <= 1'b0;
      kind_q <= EDGE_NONE;
    end else begin
      kind_q <= kind_d;
      if (!en_i)         sclk_o <= cpol_idle_i;
      else if (toggle_i) sclk_o <= ~sclk_o;
    end
  end

  assign lead_o  = (kind_q == EDGE_LEAD);
  assign trail_o = (kind_q == EDGE_TRAIL);

  AST_IDLE_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (sclk_o == $past(cpol_idle_i)) && !lead_o && !trail_o); // R6
  AST_EDGE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({lead_o, trail_o})); // R7
  AST_LEAD_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lead_o |-> sclk_o != cpol_cfg_i); // R7
  AST_TRAIL_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trail_o |-> sclk_o == cpol_cfg_i); // R8
  AST_EDGE_FLAGGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(en_i) && sclk_o != $past(sclk_o)) |-> (lead_o || trail_o)); // R7
endmodule

// File: rtl/spi_clk_div.sv
module spi_clk_div
  import spi_clk_div_pkg::*;
#(
  parameter int unsigned PRE_W  = DEF_PRE_W,
  parameter int unsigned POST_W = DEF_POST_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              cpol_i,
  input  logic [PRE_W-1:0]  pre_i,
  input  logic [POST_W-1:0] post_i,
  output logic              sclk_o,
  output logic              lead_o,
  output logic              trail_o
);
  localparam int unsigned HALF_W = PRE_W - 1;

  logic [HALF_W-1:0] half;
  logic [POST_W-1:0] post;
  logic              cpol_cfg;
  logic              tick;
  logic              toggle;

  div_cfg_latch #(.PRE_W(PRE_W), .POST_W(POST_W)) u_cfg (
    .clk_i, .rst_ni, .en_i, .cpol_i, .pre_i, .post_i,
    .half_o(half), .post_o(post), .cpol_o(cpol_cfg)
  );

  div_prescaler #(.HALF_W(HALF_W)) u_pre (
    .clk_i, .rst_ni, .en_i, .half_i(half), .tick_o(tick)
  );

  div_postscaler #(.POST_W(POST_W)) u_post (
    .clk_i, .rst_ni, .en_i, .tick_i(tick), .post_i(post), .toggle_o(toggle)
  );

  div_sclk_gen u_sclk (
    .clk_i, .rst_ni, .en_i, .toggle_i(toggle),
    .cpol_idle_i(cpol_i), .cpol_cfg_i(cpol_cfg),
    .sclk_o, .lead_o, .trail_o
  );

  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |-> (!sclk_o && !lead_o && !trail_o)); // R1
endmodule

// File: tb/spi_clk_div_bench.sv
module spi_clk_div_bench;
  localparam time CLK_PERIOD = 10ns;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b0;
  logic       cpol_i = 1'b0;
  logic [7:0] pre_i = 8'd2;
  logic [7:0] post_i = 8'd0;
  logic       sclk_o, lead_o, trail_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  spi_clk_div u_spi_clk_div (
    .clk_i, .rst_ni, .en_i, .cpol_i, .pre_i, .post_i, .sclk_o, .lead_o, .trail_o
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Capture the configuration while disabled, run for `cycles` edges and
  // compare every cycle. `swap` changes the fields mid-run (R9).
  task automatic run_case(string req, int pre_v, int post_v, bit pol,
                          int exp_half, int cycles, bit swap);
    int n;
    int tg;
    bit edg;
    @(negedge clk_i);
    en_i = 1'b0; cpol_i = pol; pre_i = 8'(pre_v); post_i = 8'(post_v);
    @(negedge clk_i);
    @(negedge clk_i);
    chk({req, " idle"}, int'(sclk_o), int'(pol));
    en_i = 1'b1;
    n = (post_v + 1) * exp_half;
    for (int k = 1; k <= cycles; k++) begin
      @(negedge clk_i);
      edg = (k % n) == 0;
      tg  = k / n;
      chk({req, " sclk"}, int'(sclk_o), int'(pol ^ tg[0]));
      chk({req, " R7 lead"}, int'(lead_o), int'(edg && tg[0]));
      chk({req, " R8 trail"}, int'(trail_o), int'(edg && !tg[0]));
      if (swap && k == cycles / 3) begin
        pre_i = 8'd2; post_i = 8'd0; cpol_i = ~pol;
      end
    end
    en_i = 1'b0;
    @(negedge clk_i);
    chk("R6 stop level", int'(sclk_o), int'(cpol_i));
    chk("R6 no lead", int'(lead_o), 0);
    chk("R6 no trail", int'(trail_o), 0);
  endtask

  task automatic t_reset;
    @(negedge clk_i);
    chk("R1 sclk", int'(sclk_o), 0);
    chk("R1 lead", int'(lead_o), 0);
    chk("R1 trail", int'(trail_o), 0);
  endtask

  task automatic t_disabled_follow;
    @(negedge clk_i);
    en_i = 1'b0;
    for (int i = 0; i < 6; i++) begin
      cpol_i = i[0];
      @(negedge clk_i);
      chk("R6 follow cpol", int'(sclk_o), int'(i[0]));
      chk("R6 quiet", int'(lead_o | trail_o), 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    run_case("R5 R10 min ratio",       2,   0, 1'b0, 1,  12, 1'b0);
    run_case("R4 pre only",            8,   0, 1'b0, 4,  40, 1'b0);
    run_case("R4 post only",           2,   4, 1'b0, 1,  40, 1'b0);
    run_case("R4 R10 both",            6,   2, 1'b0, 3,  60, 1'b0);
    run_case("R11 cpol high",          6,   2, 1'b1, 3,  60, 1'b0);
    run_case("R2 odd pre",             7,   1, 1'b0, 3,  40, 1'b0);
    run_case("R3 pre zero",            0,   2, 1'b1, 1,  30, 1'b0);
    run_case("R3 pre one",             1,   0, 1'b0, 1,  10, 1'b0);
    run_case("R9 change while on",    10,   3, 1'b0, 5, 120, 1'b1);
    run_case("R4 wide post",           4, 255, 1'b1, 2, 1100, 1'b0);
    run_case("R4 wide pre",          254,   3, 1'b0, 127, 1100, 1'b0);
    t_disabled_follow();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule